// File: doc/BRIEF.md
# Multidrop serial receiver with address filtering

This block is the receive half of an asynchronous serial port that sits on a shared multidrop line. Several nodes listen to the same line, and each one needs to react only to the traffic meant for it. Frames carry 8 data bits, or 9 bits when the ninth bit is used to mark a byte as an address (1) or as data (0). The line is sampled at sixteen times the bit rate, and each bit is decided by a majority vote around its middle.

Software programs a node address, a mask and a filter-enable bit through a small write port. While the filter is off, every completed frame loads the output byte and raises the receive flag. While the filter is on, only address frames that match pass through. A frame can match the directed pattern, which is the node address with the mask's zero bits ignored, or the broadcast pattern, which is the OR of address and mask. In 8-bit frames the stop bit stands in for the address marker. Frames that are filtered out leave no trace, and frames that finish while the flag is still set are lost.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `rx_flag`, `rx_byte` and `rx_bit9` are 0, and the address and mask registers are 0, so with the filter on any address frame is accepted.
- R2: A frame is a low start bit, then data bits LSB first, then (in 9-bit mode) the marker bit, then a stop bit. Each bit lasts 16 `tick` pulses and is taken as the majority of its samples 7, 8 and 9. A start bit that is not low at its middle is discarded and produces no frame.
- R3: With the filter off, every frame sets `rx_flag` and loads `rx_byte`. `rx_bit9` receives the marker bit in 9-bit mode and the stop bit in 8-bit mode.
- R4: With the filter on in 9-bit mode, a frame whose marker bit is 0 never sets the flag.
- R5: A directed match requires every bit where the mask is 1 to equal the address bit. Bits where the mask is 0 are ignored. Example: address 0xF1 with mask 0xFA accepts 0xF0, 0xF4 and 0xF1 and rejects 0xF3. Address 0xF3 with mask 0xF9 accepts 0xF7 and 0xF3 and rejects 0xF0.
- R6: A broadcast match requires the byte to be 1 wherever (address OR mask) is 1. With address 0xF1 and mask 0xFA, bytes 0xFB and 0xFF are accepted and 0x7B is rejected.
- R7: With the filter on in 8-bit mode, an address frame sets the flag only if it matches and its stop bit is 1. `rx_bit9` then reads 1.
- R8: While `rx_flag` is set, a newly completed frame changes neither `rx_byte` nor `rx_bit9`.
- R9: Asserting `flag_clr` while the flag is set clears it on the next clock.
- R10: Register writes take effect when `wr_en` is high. `wr_sel` 0 selects the address, 1 selects the mask, and 2 selects the control register, whose bit 0 is the filter enable. Other `wr_sel` values do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| nine_bit | input | 1 | 1 selects 9-bit frames, 0 selects 8-bit frames |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 mask, 2 control |
| wr_data | input | 8 | Write data |
| flag_clr | input | 1 | Clears the receive flag |
| rx_byte | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Marker bit (or stop bit) of the last accepted frame |
| rx_flag | output | 1 | Receive-complete flag |

## Verification
The filter is tested with two address and mask pairs, using bytes that fall on each side of the don't-care positions. This separates a masked compare from a plain equality or from ignoring the mask. Further bytes match only the broadcast pattern, so a missing broadcast path shows up as a lost frame. Data frames, 8-bit frames with good and bad stop bits, and a second frame arriving while the flag is still set check the gating on the marker bit, the stop bit and the flag. A short low pulse on the idle line checks that start-bit validation does not report a false frame.

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          nine_bit,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          flag_clr,
  output logic [DW-1:0] rx_byte,
  output logic          rx_bit9,
  output logic          rx_flag
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] VOTE = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_NINTH, S_STOP} st_t;

  st_t           state;
  logic [1:0]    rx_s;
  logic [1:0]    hist;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bit_idx;
  logic [DW-1:0] shreg;
  logic          ninth;
  logic [DW-1:0] node_addr, node_mask;
  logic          mp_en;

  wire rx_in    = rx_s[1];
  wire vote     = (hist[1] & hist[0]) | (hist[1] & rx_in) | (hist[0] & rx_in);
  wire at_vote  = tick && cnt == VOTE;
  wire at_end   = tick && cnt == LAST;
  wire [CW-1:0] cnt_nx = (cnt == LAST) ? '0 : cnt + 1'b1;

  wire frame_done = at_vote && state == S_STOP;
  wire cur_b9     = nine_bit ? ninth : vote;

  wire [DW-1:0] bc_pat = node_addr | node_mask;
  wire dir_hit = ((shreg ^ node_addr) & node_mask) == '0;
  wire bc_hit  = ((shreg ^ bc_pat) & bc_pat) == '0;
  wire pass    = !mp_en || (cur_b9 && (dir_hit || bc_hit));
  wire accept  = frame_done && !rx_flag && pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s <= 2'b11;
      hist <= 2'b11;
    end else begin
      rx_s <= {rx_s[0], rxd};
      if (tick) hist <= {hist[0], rx_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      node_addr <= '0;
      node_mask <= '0;
      mp_en     <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0:    node_addr <= wr_data;
        2'd1:    node_mask <= wr_data;
        2'd2:    mp_en     <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      ninth   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (tick && !rx_in) begin
          state <= S_START;
          cnt   <= CW'(1);
        end
        S_START: if (tick) begin
          cnt <= cnt_nx;
          if (at_vote && vote) state <= S_IDLE;
          else if (at_end) begin
            state   <= S_DATA;
            bit_idx <= '0;
          end
        end
        S_DATA: if (tick) begin
          cnt <= cnt_nx;
          if (at_vote) shreg <= {vote, shreg[DW-1:1]};
          if (at_end) begin
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == BW'(DW - 1)) state <= nine_bit ? S_NINTH : S_STOP;
          end
        end
        S_NINTH: if (tick) begin
          cnt <= cnt_nx;
          if (at_vote) ninth <= vote;
          if (at_end) state <= S_STOP;
        end
        S_STOP: if (tick) begin
          cnt <= cnt_nx;
          if (at_vote) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_flag <= 1'b0;
      rx_byte <= '0;
      rx_bit9 <= 1'b0;
    end else if (accept) begin
      rx_flag <= 1'b1;
      rx_byte <= shreg;
      rx_bit9 <= cur_b9;
    end else if (flag_clr) begin
      rx_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nine_bit,
  input logic          flag_clr,
  input logic          rx_flag,
  input logic [DW-1:0] rx_byte,
  input logic          rx_bit9,
  input logic          frame_done,
  input logic          mp_en,
  input logic          cur_b9
);
  p_flag_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag && flag_clr |=> !rx_flag);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag && !flag_clr |=> rx_flag && $stable(rx_byte) && $stable(rx_bit9));

  p_data_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && mp_en && nine_bit && !cur_b9 |=> !$rose(rx_flag));

  p_bad_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && mp_en && !nine_bit && !cur_b9 |=> !$rose(rx_flag));

  p_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !mp_en && !rx_flag |=> rx_flag);

  p_set_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(frame_done));
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .nine_bit(nine_bit), .flag_clr(flag_clr),
  .rx_flag(rx_flag), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
  .frame_done(frame_done), .mp_en(mp_en), .cur_b9(cur_b9)
);

// File: tb/mp_uart_rx_bench.sv
module mp_uart_rx_bench;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       rxd = 1'b1;
  logic       nine_bit = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       flag_clr = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_bit9;
  logic       rx_flag;

  int checks = 0;
  int fails  = 0;
  int tcnt   = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
  assign tick = (tcnt == TDIV - 1);

  mp_uart_rx u_mp_uart_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine_bit(nine_bit),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .flag_clr(flag_clr),
    .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_flag(rx_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic b9, input logic stop);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    if (nine_bit) drive_bit(b9);
    drive_bit(stop);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic probe(input string req, input logic [7:0] b, input logic b9, input logic stop,
                       input logic exp_flag);
    clr();
    send(b, b9, stop);
    chk(req, rx_flag, exp_flag);
    if (exp_flag) chk(req, rx_byte, b);
  endtask

  task automatic t_reset();
    chk("R1 flag", rx_flag, 0);
    chk("R1 byte", rx_byte, 0);
    chk("R1 bit9", rx_bit9, 0);
    nine_bit = 1'b1;
    wr(2'd2, 8'h01);
    probe("R1 zero regs accept", 8'h5A, 1'b1, 1'b1, 1'b1);
    probe("R4 data frame dropped", 8'h5A, 1'b0, 1'b1, 1'b0);
    wr(2'd3, 8'h00);
    probe("R10 sel3 no effect", 8'h33, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_open();
    nine_bit = 1'b1;
    wr(2'd2, 8'h00);
    probe("R3 data frame open", 8'hC3, 1'b0, 1'b1, 1'b1);
    chk("R3 bit9 data", rx_bit9, 0);
  endtask

  task automatic t_directed();
    nine_bit = 1'b1;
    wr(2'd0, 8'hF1);
    wr(2'd1, 8'hFA);
    wr(2'd2, 8'h01);
    probe("R5 F1/FA F0", 8'hF0, 1'b1, 1'b1, 1'b1);
    chk("R5 bit9", rx_bit9, 1);
    probe("R5 F1/FA F4", 8'hF4, 1'b1, 1'b1, 1'b1);
    probe("R5 F1/FA F1", 8'hF1, 1'b1, 1'b1, 1'b1);
    probe("R5 F1/FA F3", 8'hF3, 1'b1, 1'b1, 1'b0);
    wr(2'd0, 8'hF3);
    wr(2'd1, 8'hF9);
    probe("R5 F3/F9 F7", 8'hF7, 1'b1, 1'b1, 1'b1);
    probe("R5 F3/F9 F3", 8'hF3, 1'b1, 1'b1, 1'b1);
    probe("R5 F3/F9 F0", 8'hF0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_broadcast();
    nine_bit = 1'b1;
    wr(2'd0, 8'hF1);
    wr(2'd1, 8'hFA);
    probe("R6 FB", 8'hFB, 1'b1, 1'b1, 1'b1);
    probe("R6 FF", 8'hFF, 1'b1, 1'b1, 1'b1);
    probe("R6 7B", 8'h7B, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_eight();
    nine_bit = 1'b0;
    probe("R7 good stop", 8'hF0, 1'b0, 1'b1, 1'b1);
    chk("R7 bit9 is stop", rx_bit9, 1);
    probe("R7 bad stop", 8'hF0, 1'b0, 1'b0, 1'b0);
    wr(2'd2, 8'h00);
    probe("R3 8-bit open bad stop", 8'h96, 1'b0, 1'b0, 1'b1);
    chk("R3 bit9 from stop", rx_bit9, 0);
  endtask

  task automatic t_overrun();
    nine_bit = 1'b1;
    wr(2'd2, 8'h00);
    probe("R8 first", 8'hA5, 1'b1, 1'b1, 1'b1);
    send(8'h3C, 1'b0, 1'b1);
    chk("R8 byte kept", rx_byte, 8'hA5);
    chk("R8 bit9 kept", rx_bit9, 1);
    clr();
    chk("R9 flag cleared", rx_flag, 0);
  endtask

  task automatic t_glitch();
    nine_bit = 1'b1;
    wr(2'd2, 8'h00);
    clr();
    @(negedge clk);
    rxd = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    chk("R2 glitch no frame", rx_flag, 0);
    probe("R2 frame after glitch", 8'h69, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_open();
    t_directed();
    t_broadcast();
    t_eight();
    t_overrun();
    t_glitch();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule